// File: doc/BRIEF.md
# Receive Buffer Target Manager

This block sits on the receive side of a memory-mapped bus layer controller. It keeps a small table of buffer targets that software programs. Each target has a word-aligned base address, a buffer length in words and a received-length field. A target is free only while its received-length field is zero. At reset that field is all-ones, so every target is busy and multi-word messages are refused until software frees at least one target.

The bus side hands words to the block with first and last markers. The first word of a multi-word message also carries the announced length. The block picks a free target that is large enough, writes the words to consecutive memory words from the target's base, and records the length on the last word, which makes the target busy. A message that cannot be placed is refused with a NAK and can raise a dropped-message interrupt.

A message of one word goes to a separate single-word holding register, which software empties by reading it. Software reads and writes targets through one indexed register port. All outputs are registered, so every response appears in the cycle after the word that caused it.

Top module: `rxtm_mgr`

## Requirements
- R1: After reset every target reads as 32'hFF00_0000 (received-length field all-ones, so busy), the single-word register is empty, and mem_we, rsp_ack, rsp_nak and irq_drop are low.
- R2: A target word holds received length minus one in [31:24], buffer length minus one in [23:16] and the base word address in [15:2]. Bits [1:0] read as zero and ignore writes. Read data appears on sw_rdata in the cycle after sw_rd and holds until the next read.
- R3: A target is free only while its received-length field is zero. Writing zero to that field through the register port frees the target.
- R4: For a multi-word message, the lowest-index free target whose buffer length minus one is at least msg_len_m1 is chosen.
- R5: Word k of a stored message is written at byte address 4*(base+k), with the word address taken modulo 2^14. On the last word, rsp_ack pulses and the target's received-length field becomes the word count minus one.
- R6: If no target fits, the first word draws rsp_nak, no memory write takes place, and irq_drop pulses when cfg_drop_en is 1.
- R7: A word that would fall past the chosen target's buffer aborts reception. It draws rsp_nak and irq_drop (when enabled), it is not written, the target stays free, and the remaining words of that message are ignored.
- R8: While cfg_rx_en is 0, every new message, single-word or multi-word, draws rsp_nak with no memory write and no irq_drop.
- R9: A word flagged both first and last is a single-word message. It is captured in the single-word register with rsp_ack. A read with sw_single=1 returns the word and empties the register.
- R10: A single-word message that arrives while the single-word register is still full draws rsp_nak, plus irq_drop when enabled, and the held word is kept.
- R11: If a single-word message arrives in the same cycle as a read of the full single-word register, the read returns the older word and the new word is accepted.
- R12: If software writes a target in the same cycle that a message completes into it, the received-length field takes the hardware value and the other fields take the software value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Reception enable; 0 refuses every message |
| cfg_drop_en | input | 1 | Enable for the dropped-message interrupt |
| sw_wr | input | 1 | Write the target selected by sw_idx |
| sw_rd | input | 1 | Read request |
| sw_single | input | 1 | With sw_rd: read the single-word register instead of a target |
| sw_idx | input | 2 | Target index |
| sw_wdata | input | 32 | Target write data |
| sw_rdata | output | 32 | Registered read data |
| msg_vld | input | 1 | Incoming word valid |
| msg_first | input | 1 | First word of a message |
| msg_last | input | 1 | Last word of a message |
| msg_len_m1 | input | 8 | Announced length minus one, sampled with the first word |
| msg_data | input | 32 | Incoming word |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| rsp_ack | output | 1 | Message accepted pulse |
| rsp_nak | output | 1 | Message refused pulse |
| irq_drop | output | 1 | Dropped-message interrupt pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first is a software access to the single-word register while a new single-word message arrives. The second is a software write to a target while a message completes into that same target. The bench drives the read or the write in exactly the cycle that carries the arriving or closing word. It then judges the outcome from the returned read data, the ack or NAK pulse, and a later read-back of the target word. A behavioural model that updates on every clock predicts every output, and all outputs are compared against it every cycle.

// File: rtl/rxtm_pkg.sv
package rxtm_pkg;
  typedef enum logic [0:0] {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_st_e;
endpackage

// File: rtl/rxtm_bank.sv
module rxtm_bank #(
  parameter int NT = 4,
  parameter int LW = 8,
  parameter int BW = 14,
  localparam int IW = (NT > 1) ? $clog2(NT) : 1,
  localparam int DW = 2 * LW + BW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_wr,
  input  logic [IW-1:0] sw_idx,
  input  logic [DW-1:0] sw_wdata,
  input  logic          hw_done,
  input  logic [IW-1:0] hw_idx,
  input  logic [LW-1:0] hw_rcv,
  input  logic [LW-1:0] need_m1,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic [BW-1:0] hit_base,
  output logic [LW-1:0] hit_blen,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);
  localparam int RCV_LSB  = LW + BW + 2;
  localparam int BLEN_LSB = BW + 2;

  logic [LW-1:0] rcv_q  [NT];
  logic [LW-1:0] blen_q [NT];
  logic [BW-1:0] base_q [NT];
  logic [NT-1:0] cand;

  for (genvar g = 0; g < NT; g++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst) begin
        rcv_q[g]  <= '1;
        blen_q[g] <= '0;
        base_q[g] <= '0;
      end else begin
        if (sw_wr && sw_idx == IW'(g)) begin
          rcv_q[g]  <= sw_wdata[RCV_LSB +: LW];
          blen_q[g] <= sw_wdata[BLEN_LSB +: LW];
          base_q[g] <= sw_wdata[2 +: BW];
        end
        if (hw_done && hw_idx == IW'(g))
          rcv_q[g] <= hw_rcv;
      end
    end

    assign cand[g] = (rcv_q[g] == '0) && (blen_q[g] >= need_m1);

    p_reset_busy_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> rcv_q[g] == '1);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign hit_base = base_q[hit_idx];
  assign hit_blen = blen_q[hit_idx];
  assign rd_word  = {rcv_q[rd_idx], blen_q[rd_idx], base_q[rd_idx], 2'b00};

  p_done_marks_busy_r5: assert property (@(posedge clk) disable iff (rst)
    hw_done && hw_rcv != '0 |=> rcv_q[$past(hw_idx)] != '0);
endmodule

// File: rtl/rxtm_single.sv
module rxtm_single #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          put,
  input  logic [DW-1:0] put_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take) full <= 1'b0;
      if (put) begin
        full <= 1'b1;
        data <= put_data;
      end
    end
  end

  p_put_fills_r9: assert property (@(posedge clk) disable iff (rst)
    put |=> full);
endmodule

// File: rtl/rxtm_mgr.sv
module rxtm_mgr #(
  parameter int NT = 4,
  parameter int LW = 8,
  parameter int BW = 14,
  localparam int IW = (NT > 1) ? $clog2(NT) : 1,
  localparam int DW = 2 * LW + BW + 2,
  localparam int AW = BW + 2,
  localparam int CW = LW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_rx_en,
  input  logic          cfg_drop_en,
  input  logic          sw_wr,
  input  logic          sw_rd,
  input  logic          sw_single,
  input  logic [IW-1:0] sw_idx,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] sw_rdata,
  input  logic          msg_vld,
  input  logic          msg_first,
  input  logic          msg_last,
  input  logic [LW-1:0] msg_len_m1,
  input  logic [DW-1:0] msg_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rsp_ack,
  output logic          rsp_nak,
  output logic          irq_drop
);
  import rxtm_pkg::*;

  fill_st_e      st_q;
  logic [IW-1:0] cur_idx_q;
  logic [BW-1:0] cur_base_q;
  logic [LW-1:0] cur_blen_q;
  logic [CW-1:0] cnt_q;

  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [BW-1:0] hit_base;
  logic [LW-1:0] hit_blen;
  logic [DW-1:0] rd_word;
  logic          single_full;
  logic [DW-1:0] single_data;

  logic is_single, is_multi, in_fill, overflow, hw_done, take, single_put;
  logic [BW-1:0] next_word;

  assign is_single  = msg_vld && msg_first && msg_last && st_q == FS_IDLE;
  assign is_multi   = msg_vld && msg_first && !msg_last && st_q == FS_IDLE;
  assign in_fill    = msg_vld && st_q == FS_FILL;
  assign overflow   = in_fill && (cnt_q > {1'b0, cur_blen_q});
  assign hw_done    = in_fill && !overflow && msg_last;
  assign take       = sw_rd && sw_single;
  assign single_put = is_single && cfg_rx_en && (!single_full || take);
  assign next_word  = cur_base_q + BW'(cnt_q);

  rxtm_bank #(.NT(NT), .LW(LW), .BW(BW)) u_bank (
    .clk(clk), .rst(rst),
    .sw_wr(sw_wr), .sw_idx(sw_idx), .sw_wdata(sw_wdata),
    .hw_done(hw_done), .hw_idx(cur_idx_q), .hw_rcv(cnt_q[LW-1:0]),
    .need_m1(msg_len_m1),
    .hit(hit), .hit_idx(hit_idx), .hit_base(hit_base), .hit_blen(hit_blen),
    .rd_idx(sw_idx), .rd_word(rd_word)
  );

  rxtm_single #(.DW(DW)) u_single (
    .clk(clk), .rst(rst),
    .put(single_put), .put_data(msg_data), .take(take),
    .full(single_full), .data(single_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= FS_IDLE;
      cur_idx_q  <= '0;
      cur_base_q <= '0;
      cur_blen_q <= '0;
      cnt_q      <= '0;
      sw_rdata   <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rsp_ack    <= 1'b0;
      rsp_nak    <= 1'b0;
      irq_drop   <= 1'b0;
    end else begin
      mem_we   <= 1'b0;
      rsp_ack  <= 1'b0;
      rsp_nak  <= 1'b0;
      irq_drop <= 1'b0;
      if (sw_rd) sw_rdata <= sw_single ? single_data : rd_word;

      if (is_single) begin
        if (single_put) rsp_ack <= 1'b1;
        else begin
          rsp_nak  <= 1'b1;
          irq_drop <= cfg_rx_en && cfg_drop_en;
        end
      end else if (is_multi) begin
        if (!cfg_rx_en) rsp_nak <= 1'b1;
        else if (!hit) begin
          rsp_nak  <= 1'b1;
          irq_drop <= cfg_drop_en;
        end else begin
          mem_we     <= 1'b1;
          mem_addr   <= {hit_base, 2'b00};
          mem_wdata  <= msg_data;
          cur_idx_q  <= hit_idx;
          cur_base_q <= hit_base;
          cur_blen_q <= hit_blen;
          cnt_q      <= CW'(1);
          st_q       <= FS_FILL;
        end
      end else if (in_fill) begin
        if (overflow) begin
          rsp_nak  <= 1'b1;
          irq_drop <= cfg_drop_en;
          st_q     <= FS_IDLE;
        end else begin
          mem_we    <= 1'b1;
          mem_addr  <= {next_word, 2'b00};
          mem_wdata <= msg_data;
          cnt_q     <= cnt_q + CW'(1);
          if (msg_last) begin
            rsp_ack <= 1'b1;
            st_q    <= FS_IDLE;
          end
        end
      end
    end
  end

  p_ack_nak_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ack && rsp_nak));
  p_drop_with_nak_r6: assert property (@(posedge clk) disable iff (rst)
    irq_drop |-> rsp_nak);
  p_disabled_refuses_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == FS_IDLE && msg_vld && msg_first && !cfg_rx_en)
    |=> (rsp_nak && !rsp_ack && !mem_we && !irq_drop));
  p_single_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (is_single && single_full && !take) |=> (rsp_nak && !rsp_ack));
  p_fill_window_r7: assert property (@(posedge clk) disable iff (rst)
    st_q == FS_FILL |-> cnt_q <= {1'b0, cur_blen_q} + CW'(1));
endmodule

// File: tb/rxtm_mgr_test.sv
module rxtm_mgr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_rx_en = 1'b1, cfg_drop_en = 1'b1;
  logic        sw_wr = 0, sw_rd = 0, sw_single = 0;
  logic [1:0]  sw_idx = 0;
  logic [31:0] sw_wdata = 0;
  logic [31:0] sw_rdata;
  logic        msg_vld = 0, msg_first = 0, msg_last = 0;
  logic [7:0]  msg_len_m1 = 0;
  logic [31:0] msg_data = 0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        rsp_ack, rsp_nak, irq_drop;

  always #5 clk = ~clk;

  rxtm_mgr uut (
    .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_drop_en(cfg_drop_en),
    .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_single(sw_single), .sw_idx(sw_idx),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .msg_vld(msg_vld), .msg_first(msg_first), .msg_last(msg_last),
    .msg_len_m1(msg_len_m1), .msg_data(msg_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rsp_ack(rsp_ack), .rsp_nak(rsp_nak), .irq_drop(irq_drop)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int e_rcv[4], e_blen[4], e_base[4];
  bit e_sfull, e_fill;
  int e_sdata, e_idx, e_cnt, e_cbase, e_cblen;
  bit e_we, e_ack, e_nak, e_drop;
  int e_addr, e_wd, e_rdata;

  function automatic int pack(int r, int b, int a);
    return (r << 24) | (b << 16) | (a << 2);
  endfunction

  always @(posedge clk) begin
    int o_rcv[4], o_blen[4], o_base[4];
    bit o_sfull, o_fill, tk;
    int o_sdata, pick;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin e_rcv[i] = 255; e_blen[i] = 0; e_base[i] = 0; end
      e_sfull = 0; e_fill = 0; e_sdata = 0; e_idx = 0; e_cnt = 0; e_cbase = 0; e_cblen = 0;
      e_we = 0; e_ack = 0; e_nak = 0; e_drop = 0; e_addr = 0; e_wd = 0; e_rdata = 0;
    end else begin
      o_rcv = e_rcv; o_blen = e_blen; o_base = e_base;
      o_sfull = e_sfull; o_fill = e_fill; o_sdata = e_sdata;
      e_we = 0; e_ack = 0; e_nak = 0; e_drop = 0;
      tk = sw_rd && sw_single;
      if (sw_rd) e_rdata = sw_single ? o_sdata : pack(o_rcv[sw_idx], o_blen[sw_idx], o_base[sw_idx]);
      if (tk) e_sfull = 0;
      if (sw_wr) begin
        e_rcv[sw_idx] = sw_wdata[31:24]; e_blen[sw_idx] = sw_wdata[23:16]; e_base[sw_idx] = sw_wdata[15:2];
      end
      if (!o_fill && msg_vld && msg_first && msg_last) begin
        if (cfg_rx_en && (!o_sfull || tk)) begin
          e_sfull = 1; e_sdata = msg_data; e_ack = 1;
        end else begin
          e_nak = 1; e_drop = cfg_rx_en && cfg_drop_en;
        end
      end else if (!o_fill && msg_vld && msg_first) begin
        if (!cfg_rx_en) e_nak = 1;
        else begin
          pick = -1;
          for (int i = 3; i >= 0; i--)
            if (o_rcv[i] == 0 && o_blen[i] >= int'(msg_len_m1)) pick = i;
          if (pick < 0) begin e_nak = 1; e_drop = cfg_drop_en; end
          else begin
            e_we = 1; e_addr = o_base[pick] * 4; e_wd = msg_data;
            e_idx = pick; e_cbase = o_base[pick]; e_cblen = o_blen[pick];
            e_cnt = 1; e_fill = 1;
          end
        end
      end else if (o_fill && msg_vld) begin
        if (e_cnt > e_cblen) begin
          e_nak = 1; e_drop = cfg_drop_en; e_fill = 0;
        end else begin
          e_we = 1; e_addr = ((e_cbase + e_cnt) % 16384) * 4; e_wd = msg_data;
          e_cnt++;
          if (msg_last) begin
            e_ack = 1; e_rcv[e_idx] = e_cnt - 1; e_fill = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(cur_req, {28'd0, mem_we, rsp_ack, rsp_nak, irq_drop}, {28'd0, e_we, e_ack, e_nak, e_drop});
      if (e_we) begin
        chk(cur_req, {16'd0, mem_addr}, e_addr);
        chk(cur_req, mem_wdata, e_wd);
      end
      chk(cur_req, sw_rdata, e_rdata);
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic rd_tgt(input int idx, input logic [31:0] exp, input string req);
    sw_rd = 1; sw_single = 0; sw_idx = 2'(idx);
    cyc();
    sw_rd = 0;
    chk(req, sw_rdata, exp);
  endtask

  task automatic rd_single(input logic [31:0] exp, input string req);
    sw_rd = 1; sw_single = 1;
    cyc();
    sw_rd = 0; sw_single = 0;
    chk(req, sw_rdata, exp);
  endtask

  task automatic wr_tgt(input int idx, input logic [31:0] w);
    sw_wr = 1; sw_idx = 2'(idx); sw_wdata = w;
    cyc();
    sw_wr = 0;
  endtask

  int g_acks, g_naks, g_drops, g_writes, g_last_addr;
  bit conc_en = 0; int conc_idx; logic [31:0] conc_word;

  task automatic send(input int hint, input int n, input logic [31:0] d0);
    g_acks = 0; g_naks = 0; g_drops = 0; g_writes = 0; g_last_addr = -1;
    for (int k = 0; k < n; k++) begin
      msg_vld = 1; msg_first = (k == 0); msg_last = (k == n - 1);
      msg_len_m1 = 8'(hint); msg_data = d0 + 32'(k);
      if (conc_en && k == n - 1) begin sw_wr = 1; sw_idx = 2'(conc_idx); sw_wdata = conc_word; end
      cyc();
      sw_wr = 0;
      g_acks += int'(rsp_ack); g_naks += int'(rsp_nak); g_drops += int'(irq_drop);
      if (mem_we) begin g_writes++; g_last_addr = int'(mem_addr); end
    end
    msg_vld = 0; msg_first = 0; msg_last = 0;
    cyc();
    g_acks += int'(rsp_ack); g_naks += int'(rsp_nak); g_drops += int'(irq_drop);
    if (mem_we) begin g_writes++; g_last_addr = int'(mem_addr); end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cur_req = "R1";
    chk("R1", {29'd0, mem_we, rsp_ack, rsp_nak}, 32'd0);
    for (int i = 0; i < 4; i++) rd_tgt(i, 32'hFF00_0000, "R1");

    cur_req = "R2";
    wr_tgt(0, 32'h0003_0103);
    rd_tgt(0, 32'h0003_0100, "R2");
    wr_tgt(1, 32'h0007_0200);
    wr_tgt(2, 32'h050F_0300);
    wr_tgt(3, 32'h000F_0400);

    cur_req = "R4";
    send(5, 6, 32'hA000_0000);
    chk("R4", g_writes, 6); chk("R5", g_last_addr, 32'h214); chk("R5", g_acks, 1);
    rd_tgt(1, 32'h0507_0200, "R5");
    send(2, 3, 32'hB000_0000);
    chk("R4", g_last_addr, 32'h108);
    rd_tgt(0, 32'h0203_0100, "R4");
    cur_req = "R3";
    send(2, 3, 32'hC000_0000);
    rd_tgt(3, 32'h020F_0400, "R3");
    wr_tgt(1, 32'h0007_0200);
    rd_tgt(1, 32'h0007_0200, "R3");

    cur_req = "R6";
    send(20, 2, 32'hD000_0000);
    chk("R6", {g_naks, g_drops, g_writes}, {32'd1, 32'd1, 32'd0});
    cfg_drop_en = 0;
    send(20, 2, 32'hD100_0000);
    chk("R6", {g_naks, g_drops}, {32'd1, 32'd0});
    cfg_drop_en = 1;

    cur_req = "R7";
    send(1, 10, 32'hE000_0000);
    chk("R7", {g_writes, g_naks, g_acks, g_drops}, {32'd8, 32'd1, 32'd0, 32'd1});
    rd_tgt(1, 32'h0007_0200, "R7");

    cur_req = "R8";
    cfg_rx_en = 0;
    send(0, 1, 32'h1234_5678);
    chk("R8", {g_naks, g_drops, g_acks}, {32'd1, 32'd0, 32'd0});
    send(1, 2, 32'h2234_5678);
    chk("R8", {g_naks, g_drops, g_writes}, {32'd1, 32'd0, 32'd0});
    rd_tgt(1, 32'h0007_0200, "R8");
    cfg_rx_en = 1;

    cur_req = "R9";
    send(0, 1, 32'h1111_1111);
    chk("R9", g_acks, 1);
    rd_single(32'h1111_1111, "R9");
    cur_req = "R10";
    send(0, 1, 32'h2222_2222);
    send(0, 1, 32'h3333_3333);
    chk("R10", {g_naks, g_drops}, {32'd1, 32'd1});
    rd_single(32'h2222_2222, "R10");

    cur_req = "R11";
    send(0, 1, 32'h4444_4444);
    msg_vld = 1; msg_first = 1; msg_last = 1; msg_data = 32'h5555_5555;
    sw_rd = 1; sw_single = 1;
    cyc();
    msg_vld = 0; msg_first = 0; msg_last = 0; sw_rd = 0; sw_single = 0;
    chk("R11", sw_rdata, 32'h4444_4444);
    chk("R11", {31'd0, rsp_ack}, 32'd1);
    cyc();
    rd_single(32'h5555_5555, "R11");

    cur_req = "R12";
    conc_en = 1; conc_idx = 1; conc_word = 32'h000A_0C00;
    send(2, 3, 32'hF000_0000);
    conc_en = 0;
    chk("R12", g_acks, 1);
    rd_tgt(1, 32'h020A_0C00, "R12");

    cyc();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule